// File: doc/BRIEF.md
# Single-Cycle Register Datapath

This block is the execution half of a single-cycle processor. It holds a small bank of registers and moves data between them through a function unit in one clock period. Every cycle, two registers are read without waiting for a clock. One of them drives the address bus. The other, or a constant supplied from outside, drives the data-out bus. The function unit combines the two operands and produces a result together with four status flags. A write-back multiplexer then picks either that result or an external data word. If the load enable is high, the chosen value is stored into the destination register at the next rising clock edge.

A controller drives the register selects, the function code and the multiplexer controls for each instruction. With this arrangement a transfer such as "register 1 gets register 2 plus register 3" finishes in a single edge. Instruction fetch, decode and memory are outside this block.

Top module: `sc_datapath`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge clears every register to 0.
- R2: `addr_bus` always shows the register chosen by `a_sel`, with no clock delay.
- R3: `dout_bus` shows `const_in` when `const_sel` is 1, and otherwise the register chosen by `b_sel`, with no clock delay.
- R4: The write-back value is `ext_data` when `ext_sel` is 1 and the function result otherwise. At a rising edge with `load_en` high, it is stored into the register chosen by `d_sel`.
- R5: At an edge with `load_en` low and `rst` low, no register changes, whatever the other inputs are.
- R6: A register may be a source and the destination of the same operation. The stored result uses the values the register held before the edge.
- R7: When `fsel[3]` is 0, the result is A + Y + `fsel[0]` modulo 2^WIDTH. Y is selected by `fsel[2:1]`: 00 gives zero, 01 gives B, 10 gives the bitwise inverse of B, and 11 gives all ones. This yields pass A (0000), A+1 (0001), A+B (0010), A-B (0101) and A-1 (0110).
- R8: When `fsel[3]` is 1, `fsel[2:1]` selects a bitwise operation: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 gives NOT A. The value of `fsel[0]` has no effect on these operations.
- R9: For arithmetic codes, `flag_c` is the carry out of the most significant bit and `flag_v` is set on two's-complement overflow of A + Y + `fsel[0]`. For logic codes, both flags are 0.
- R10: `flag_n` equals the most significant bit of the function result and `flag_z` is 1 exactly when that result is zero. Both describe the function result even when `ext_sel` selects external data.
- R11: A write changes only the destination register. The other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_sel | input | 2 | Register shown on the address bus (A operand) |
| b_sel | input | 2 | Register routed to the B operand |
| d_sel | input | 2 | Destination register for write-back |
| const_sel | input | 1 | 1: the B operand is `const_in` |
| const_in | input | 8 | Constant operand |
| fsel | input | 4 | Function code {S2, S1, S0, carry-in} |
| ext_sel | input | 1 | 1: write back `ext_data` instead of the function result |
| load_en | input | 1 | Enables the register write |
| ext_data | input | 8 | External data word |
| addr_bus | output | 8 | A operand, also the outgoing address |
| dout_bus | output | 8 | B operand, also the outgoing data |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The hard cases are the signed overflow corners and the carry cases on the boundaries of the word, such as 0x7F+1, 0x80-1 and 0xFF+1. They are only reachable if chosen operands sit in the registers and in the constant path at the same time. The bench loads the A operand through the external-data path in one cycle and supplies B through the constant input. It applies every function code, then writes the result into a spare register and reads it back on the address bus. This sweeps all 16 codes against a grid of boundary operands, checking the flags combinationally before the edge and the stored result after it.

// File: rtl/sc_dp_pkg.sv
package sc_dp_pkg;

    // Operand chosen as Y for the adder when the code is arithmetic
    typedef enum logic [1:0] {
        Y_ZERO  = 2'b00,
        Y_B     = 2'b01,
        Y_NOT_B = 2'b10,
        Y_ONES  = 2'b11
    } y_src_e;

    // Bitwise operation when the code is logic
    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_NOT = 2'b11
    } lop_e;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } flags_t;

endpackage

// File: rtl/sc_dp_regfile.sv
module sc_dp_regfile #(
    parameter  int WIDTH = 8,
    parameter  int NREG  = 4,
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] rd_a_sel,
    input  logic [SEL_W-1:0] rd_b_sel,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b
);

    typedef struct packed {
        logic [NREG-1:0][WIDTH-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_sel) < NREG)) begin
            st_d.regs[wr_sel] = wr_data;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Reads are combinational: a same-cycle source sees the pre-edge value
    assign rd_a = st_q.regs[rd_a_sel];
    assign rd_b = st_q.regs[rd_b_sel];

endmodule

// File: rtl/sc_dp_mux2.sv
module sc_dp_mux2 #(
    parameter int WIDTH = 8
) (
    input  logic             sel,
    input  logic [WIDTH-1:0] in0,
    input  logic [WIDTH-1:0] in1,
    output logic [WIDTH-1:0] out
);

    always_comb begin
        out = sel ? in1 : in0;
    end

endmodule

// File: rtl/sc_dp_func.sv
module sc_dp_func
    import sc_dp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       fsel,
    output logic [WIDTH-1:0] f,
    output flags_t           flags
);

    logic [WIDTH:0]   cy;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    logic             is_logic;
    y_src_e           y_src;
    lop_e             lop;

    assign is_logic = fsel[3];
    assign y_src    = y_src_e'(fsel[2:1]);
    assign lop      = lop_e'(fsel[2:1]);
    assign cy[0]    = fsel[0];

    // Ripple stage per bit: operand conditioning, sum and carry
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic yb;
        always_comb begin
            unique case (y_src)
                Y_ZERO:  yb = 1'b0;
                Y_B:     yb = b[i];
                Y_NOT_B: yb = ~b[i];
                default: yb = 1'b1;
            endcase
        end
        assign arith_res[i] = a[i] ^ yb ^ cy[i];
        assign cy[i+1]      = (a[i] & yb) | (cy[i] & (a[i] ^ yb));
    end

    always_comb begin
        unique case (lop)
            LOP_AND: logic_res = a & b;
            LOP_OR:  logic_res = a | b;
            LOP_XOR: logic_res = a ^ b;
            default: logic_res = ~a;
        endcase
    end

    // Output multiplexer between the arithmetic and logic halves
    sc_dp_mux2 #(.WIDTH(WIDTH)) i_out_mux (
        .sel (is_logic),
        .in0 (arith_res),
        .in1 (logic_res),
        .out (f)
    );

    always_comb begin
        flags.c = ~is_logic & cy[WIDTH];
        flags.v = ~is_logic & (cy[WIDTH] ^ cy[WIDTH-1]);
        flags.n = f[WIDTH-1];
        flags.z = ~|f;
    end

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
    import sc_dp_pkg::*;
#(
    parameter  int WIDTH = 8,
    parameter  int NREG  = 4,
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] a_sel,
    input  logic [SEL_W-1:0] b_sel,
    input  logic [SEL_W-1:0] d_sel,
    input  logic             const_sel,
    input  logic [WIDTH-1:0] const_in,
    input  logic [3:0]       fsel,
    input  logic             ext_sel,
    input  logic             load_en,
    input  logic [WIDTH-1:0] ext_data,
    output logic [WIDTH-1:0] addr_bus,
    output logic [WIDTH-1:0] dout_bus,
    output logic             flag_c,
    output logic             flag_v,
    output logic             flag_n,
    output logic             flag_z
);

    logic [WIDTH-1:0] reg_a;
    logic [WIDTH-1:0] reg_b;
    logic [WIDTH-1:0] b_bus;
    logic [WIDTH-1:0] func_out;
    logic [WIDTH-1:0] d_bus;
    flags_t           flags;

    sc_dp_regfile #(.WIDTH(WIDTH), .NREG(NREG)) i_regfile (
        .clk      (clk),
        .rst      (rst),
        .rd_a_sel (a_sel),
        .rd_b_sel (b_sel),
        .wr_sel   (d_sel),
        .wr_en    (load_en),
        .wr_data  (d_bus),
        .rd_a     (reg_a),
        .rd_b     (reg_b)
    );

    sc_dp_mux2 #(.WIDTH(WIDTH)) i_b_mux (
        .sel (const_sel),
        .in0 (reg_b),
        .in1 (const_in),
        .out (b_bus)
    );

    sc_dp_func #(.WIDTH(WIDTH)) i_func (
        .a     (reg_a),
        .b     (b_bus),
        .fsel  (fsel),
        .f     (func_out),
        .flags (flags)
    );

    sc_dp_mux2 #(.WIDTH(WIDTH)) i_d_mux (
        .sel (ext_sel),
        .in0 (func_out),
        .in1 (ext_data),
        .out (d_bus)
    );

    assign addr_bus = reg_a;
    assign dout_bus = b_bus;
    assign flag_c   = flags.c;
    assign flag_v   = flags.v;
    assign flag_n   = flags.n;
    assign flag_z   = flags.z;

endmodule

// File: rtl/sc_dp_checker.sv
module sc_dp_checker #(
    parameter int WIDTH = 8,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] a_sel,
    input logic [SEL_W-1:0] b_sel,
    input logic [SEL_W-1:0] d_sel,
    input logic             const_sel,
    input logic [WIDTH-1:0] const_in,
    input logic [3:0]       fsel,
    input logic             ext_sel,
    input logic             load_en,
    input logic [WIDTH-1:0] ext_data,
    input logic [WIDTH-1:0] addr_bus,
    input logic [WIDTH-1:0] dout_bus,
    input logic             flag_c,
    input logic             flag_v,
    input logic             flag_n,
    input logic             flag_z
);

    logic armed_q;
    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    AST_SAME_SEL_SAME_VALUE: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (!const_sel && b_sel == a_sel) |-> (dout_bus == addr_bus)); // R3

    AST_EXT_WRITEBACK: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (load_en && ext_sel) |=> (($past(d_sel) != a_sel) || (addr_bus == $past(ext_data)))); // R4

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (!load_en) |=> ((a_sel != $past(a_sel)) || (addr_bus == $past(addr_bus)))); // R5

    AST_ADD_WRITEBACK: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (load_en && !ext_sel && fsel == 4'b0010) |=>
        (($past(d_sel) != a_sel) ||
         (addr_bus == WIDTH'($past(addr_bus) + $past(dout_bus))))); // R6

    AST_CONST_OR_WRITEBACK: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (load_en && !ext_sel && const_sel && fsel == 4'b1010) |=>
        (($past(d_sel) != a_sel) || (addr_bus == ($past(addr_bus) | $past(const_in))))); // R8

    AST_LOGIC_NO_CV: assert property (@(posedge clk) disable iff (rst || !armed_q)
        fsel[3] |-> (!flag_c && !flag_v)); // R9

    AST_PASS_FLAGS: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (fsel == 4'b0000) |-> ((flag_n == addr_bus[WIDTH-1]) && (flag_z == (addr_bus == '0)))); // R10

endmodule

bind sc_datapath sc_dp_checker #(.WIDTH(WIDTH), .SEL_W(SEL_W)) i_sc_dp_checker (.*);

// File: tb/test_sc_datapath.sv
`timescale 1ns/1ps
module test_sc_datapath;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   a_sel, b_sel, d_sel;
    logic         const_sel;
    logic [W-1:0] const_in;
    logic [3:0]   fsel;
    logic         ext_sel, load_en;
    logic [W-1:0] ext_data;
    logic [W-1:0] addr_bus, dout_bus;
    logic         flag_c, flag_v, flag_n, flag_z;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    sc_datapath i_sc_datapath (
        .clk(clk), .rst(rst), .a_sel(a_sel), .b_sel(b_sel), .d_sel(d_sel),
        .const_sel(const_sel), .const_in(const_in), .fsel(fsel),
        .ext_sel(ext_sel), .load_en(load_en), .ext_data(ext_data),
        .addr_bus(addr_bus), .dout_bus(dout_bus),
        .flag_c(flag_c), .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_ext(input int idx, input int val);
        d_sel = 2'(idx); ext_sel = 1'b1; ext_data = W'(val); load_en = 1'b1;
        tick();
        load_en = 1'b0; ext_sel = 1'b0;
    endtask

    task automatic read_reg(input int idx, output int val);
        a_sel = 2'(idx);
        #1;
        val = int'(addr_bus);
    endtask

    // Reference: result[7:0], c at bit 8, v at bit 9
    function automatic int model(input int fs, input int a, input int b);
        int y, cin, res, c, v, sa, sy, ssum;
        if (fs >= 8) begin
            case ((fs >> 1) & 3)
                0: res = a & b;
                1: res = a | b;
                2: res = a ^ b;
                default: res = (~a) & 255;
            endcase
            return res;
        end
        case ((fs >> 1) & 3)
            0: y = 0;
            1: y = b;
            2: y = 255 - b;
            default: y = 255;
        endcase
        cin  = fs & 1;
        res  = a + y + cin;
        c    = (res > 255) ? 1 : 0;
        sa   = (a > 127) ? a - 256 : a;
        sy   = (y > 127) ? y - 256 : y;
        ssum = sa + sy + cin;
        v    = (ssum > 127 || ssum < -128) ? 1 : 0;
        return (res & 255) | (c << 8) | (v << 9);
    endfunction

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        int vals [12] = '{8'h00, 8'h01, 8'h02, 8'h7E, 8'h7F, 8'h80,
                          8'h81, 8'h55, 8'hAA, 8'hFE, 8'hFF, 8'h3C};
        int r, m, got;
        rst = 1'b1; a_sel = 0; b_sel = 0; d_sel = 0; const_sel = 0; const_in = 0;
        fsel = 0; ext_sel = 0; load_en = 0; ext_data = 0;
        @(negedge clk);
        tick();
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            read_reg(i, r); check("R1 reset state", r, 0);
        end

        // R2 / R3: distinct contents, both read ports
        for (int i = 0; i < 4; i++) write_ext(i, 8'h11 * (i + 3));
        for (int i = 0; i < 4; i++) begin
            read_reg(i, r); check("R2 a-bus read", r, 8'h11 * (i + 3));
            b_sel = 2'(i); const_sel = 0; #1;
            check("R3 b-bus register", int'(dout_bus), 8'h11 * (i + 3));
            const_sel = 1; const_in = W'(8'hC3 ^ i); #1;
            check("R3 b-bus constant", int'(dout_bus), 8'hC3 ^ i);
        end
        const_sel = 0;

        // R5: no load, varied controls
        for (int i = 0; i < 4; i++) begin
            d_sel = 2'(i); ext_sel = i[0]; ext_data = 8'hEE; fsel = 4'(i * 3);
            load_en = 0; tick();
        end
        ext_sel = 0;
        for (int i = 0; i < 4; i++) begin
            read_reg(i, r); check("R5 hold without load", r, 8'h11 * (i + 3));
        end

        // R11: write only register 2
        write_ext(2, 8'h5A);
        for (int i = 0; i < 4; i++) begin
            read_reg(i, r);
            check("R11 only destination written", r, (i == 2) ? 8'h5A : 8'h11 * (i + 3));
        end

        // R6: R1 <- R1 + R1, then R1 <- R2 + R3
        write_ext(1, 8'h23);
        a_sel = 1; b_sel = 1; const_sel = 0; fsel = 4'b0010; d_sel = 1; load_en = 1;
        tick(); load_en = 0;
        read_reg(1, r); check("R6 source equals destination", r, 8'h46);
        write_ext(2, 8'h10); write_ext(3, 8'h25);
        a_sel = 2; b_sel = 3; fsel = 4'b0010; d_sel = 1; load_en = 1;
        tick(); load_en = 0;
        read_reg(1, r); check("R6 R1<-R2+R3 in one edge", r, 8'h35);

        // R4 / R10: external write while flags show function result
        write_ext(0, 8'hF0);
        a_sel = 0; const_sel = 1; const_in = 8'h0F; fsel = 4'b1000;
        ext_sel = 1; ext_data = 8'h99; d_sel = 3; load_en = 1; #1;
        check("R10 zero flag under ext select", int'(flag_z), 1);
        check("R10 negative flag under ext select", int'(flag_n), 0);
        tick(); load_en = 0; ext_sel = 0; const_sel = 0;
        read_reg(3, r); check("R4 external data written", r, 8'h99);

        // Sweep: every function code over boundary operands
        for (int fs = 0; fs < 16; fs++) begin
            for (int ia = 0; ia < 12; ia++) begin
                for (int ib = 0; ib < 12; ib++) begin
                    write_ext(0, vals[ia]);
                    m = model(fs, vals[ia], vals[ib]);
                    a_sel = 0; const_sel = 1; const_in = W'(vals[ib]); fsel = 4'(fs);
                    ext_sel = 0; d_sel = 2; load_en = 1; #1;
                    check("R9 carry flag", int'(flag_c), (m >> 8) & 1);
                    check("R9 overflow flag", int'(flag_v), (m >> 9) & 1);
                    check("R10 negative flag", int'(flag_n), (m >> 7) & 1);
                    check("R10 zero flag", int'(flag_z), ((m & 255) == 0) ? 1 : 0);
                    tick(); load_en = 0; const_sel = 0;
                    read_reg(2, got);
                    check((fs >= 8) ? "R8 logic result" : "R7 arithmetic result", got, m & 255);
                end
            end
        end

        // R1: reset after activity clears every register
        for (int i = 0; i < 4; i++) write_ext(i, 8'hA0 + i);
        rst = 1; tick(); rst = 0;
        for (int i = 0; i < 4; i++) begin
            read_reg(i, r); check("R1 reset clears registers", r, 0);
        end

        done = 1;
        finish_run();
    end

endmodule